// File: doc/BRIEF.md
# Phase-Shifted Dual PWM Generator

This block drives two square-wave channels from one free-running master count. The reference channel is tied to the master count. It rises when the count wraps and falls at half the period. The follower channel has its own counter. A match between the master count and a phase compare value restarts that counter, so the follower is a delayed copy of the reference. Each channel also has an inverted output for a complementary switch pair.

Period, phase and a preload flag are set through a small write port. With preload on, new period and phase values reach the active compare logic only when the master count wraps. With preload off they take effect on the next clock edge. A per-period restart latch allows at most one follower restart between two master wraps. If the follower counter reaches the period without a restart, it holds there and does not wrap. Because of these two rules, a phase step of more than half a period, in either direction, never produces a narrow pulse.

Top module: `phase_pwm`

## Requirements
- R1: After reset, preload is on, the active period is 0xFFFF and the phase value is 0. Both PWM outputs are low and both inverted outputs are high while reset is held. After enable with no writes, the reference stays low for at least 2000 cycles and the follower is high.
- R2: The master count runs from 0 to the period P and wraps to 0. The reference is high while the master count is in 0..P>>1. For odd P this gives (P+1)/2 high cycles in a P+1 cycle period.
- R3: Each inverted output is the logical inverse of its PWM output at all times.
- R4: In steady state, the follower is the reference delayed by S+1 cycles, where S is the clamped phase value. Its high time equals the reference high time.
- R5: The write port uses address 0 for the period, address 1 for the phase value and address 2 for control. Bit 0 of the control word is the preload flag. With preload on, the active phase and period change only at a master wrap, so a phase written early in a period leaves that period's restart point unchanged.
- R6: With preload off, a written phase applies from the next cycle. The follower restarts at most once between two master wraps. Without a restart, the follower counter holds at P.
- R7: Phase steps of +60%, -60%, +70% and -70% of the period, written at any point in the period and with preload on or off, never produce a follower high or low pulse shorter than (P+1)/2 cycles.
- R8: A phase value of P or more is clamped to P-1. A phase value of 1 or 2 is raised to 3. A phase value of 0 is kept.
- R9: A half-period compare of 0 (P of 0 or 1) is zero duty, and neither output ever rises. A half-period compare of 1 or 2 is raised to 3, so P=5 gives 4 high cycles in 6.
- R10: While enable is low, the counters are 0, the PWM outputs are low and the inverted outputs are high. Writes made while disabled are used once enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the counters and outputs idle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 period, 1 phase, 2 control |
| wr_data_i | input | CNT_W | Write data; control bit 0 is preload |
| ref_pwm_o | output | 1 | Reference channel PWM |
| ref_pwm_n_o | output | 1 | Reference channel inverted PWM |
| sec_pwm_o | output | 1 | Follower channel PWM |
| sec_pwm_n_o | output | 1 | Follower channel inverted PWM |

## Verification
The steady-state table combines odd periods with phase values at zero, mid-range, in the raised 1–2 band and at or past the period. This separates a wrong lag, a missing clamp and a wrong half-period compare. Large phase steps are written at several offsets within the period, once with preload on and once with preload off. Writing late in the period exposes a double restart as a narrow pulse. A phase written just after the wrap tells immediate loading apart from wrap-aligned loading. Tiny periods exercise the zero-duty and raised half-period paths.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  typedef enum logic [1:0] {
    ADDR_PERIOD = 2'd0,
    ADDR_SHIFT  = 2'd1,
    ADDR_CTRL   = 2'd2
  } reg_addr_e;

  localparam int unsigned N_CH    = 2;
  localparam int unsigned MIN_CMP = 3;
endpackage

// File: rtl/phase_pwm_regs.sv
module phase_pwm_regs import phase_pwm_pkg::*; #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          rollover_i,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] half_o,
  output logic [CW-1:0] shift_o,
  output logic          preload_o
);
  localparam logic [CW-1:0] CMP_FLOOR = CW'(MIN_CMP);

  logic [CW-1:0] per_sh, sh_sh, per_q, sh_q;
  logic [CW-1:0] per_src, sh_src, shift_lim, sh_sat;
  logic          pre_q, wr_per, wr_sh, wr_ctl, load;

  // compare values 1 and 2 are too close to the wrap edge
  function automatic logic [CW-1:0] lift(input logic [CW-1:0] v);
    return (v == CW'(1) || v == CW'(2)) ? CMP_FLOOR : v;
  endfunction

  assign wr_per  = wr_en_i && (wr_addr_i == ADDR_PERIOD);
  assign wr_sh   = wr_en_i && (wr_addr_i == ADDR_SHIFT);
  assign wr_ctl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign per_src = wr_per ? wr_data_i : per_sh;
  assign sh_src  = wr_sh  ? wr_data_i : sh_sh;
  assign load    = !en_i || !pre_q || rollover_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh <= '1;
      sh_sh  <= '0;
      per_q  <= '1;
      sh_q   <= '0;
      pre_q  <= 1'b1;
    end else begin
      per_sh <= per_src;
      sh_sh  <= sh_src;
      if (wr_ctl) pre_q <= wr_data_i[0];
      if (load) begin
        per_q <= per_src;
        sh_q  <= sh_src;
      end
    end
  end

  assign shift_lim = (per_q == '0) ? '0 : per_q - 1'b1;
  assign sh_sat    = (sh_q > shift_lim) ? shift_lim : sh_q;

  assign per_o     = per_q;
  assign half_o    = lift(per_q >> 1);
  assign shift_o   = lift(sh_sat);
  assign preload_o = pre_q;
endmodule

// File: rtl/phase_pwm_sync.sv
module phase_pwm_sync #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] m_cnt_i,
  input  logic [CW-1:0] shift_i,
  input  logic          wrap_i,
  output logic          restart_o
);
  logic hit, done_q;

  assign hit       = en_i && (m_cnt_i == shift_i);
  assign restart_o = hit && !done_q;

  // one restart per master period; cleared at the wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q <= 1'b0;
    else if (!en_i || wrap_i)   done_q <= 1'b0;
    else if (restart_o)         done_q <= 1'b1;
  end
endmodule

// File: rtl/phase_pwm_chan.sv
module phase_pwm_chan #(
  parameter int unsigned CW     = 16,
  parameter bit          FOLLOW = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] half_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          at_end, set_evt, pwm_q;

  assign at_end = (cnt_q >= per_i);

  if (FOLLOW) begin : g_follow
    // restarted only by the master compare; parks at the period otherwise
    assign set_evt = restart_i;
    assign cnt_nxt = restart_i ? '0 : (at_end ? cnt_q : cnt_q + 1'b1);
  end else begin : g_free
    assign set_evt = at_end | restart_i;
    assign cnt_nxt = set_evt ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (set_evt && half_i != '0) pwm_q <= 1'b1;
      else if (cnt_q == half_i)    pwm_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm import phase_pwm_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             ref_pwm_o,
  output logic             ref_pwm_n_o,
  output logic             sec_pwm_o,
  output logic             sec_pwm_n_o
);
  logic [CNT_W-1:0] per_act, half_cmp, sh_cmp, m_cnt, s_cnt;
  logic             preload, m_wrap, sec_restart;
  logic [N_CH-1:0]  pwm, restart_vec;
  logic [CNT_W-1:0] cnt [N_CH];

  phase_pwm_regs #(.CW(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rollover_i (m_wrap),
    .per_o      (per_act),
    .half_o     (half_cmp),
    .shift_o    (sh_cmp),
    .preload_o  (preload)
  );

  assign m_cnt  = cnt[0];
  assign s_cnt  = cnt[1];
  assign m_wrap = en_i && (m_cnt >= per_act);

  phase_pwm_sync #(.CW(CNT_W)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .m_cnt_i   (m_cnt),
    .shift_i   (sh_cmp),
    .wrap_i    (m_wrap),
    .restart_o (sec_restart)
  );

  assign restart_vec = {sec_restart, 1'b0};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    phase_pwm_chan #(
      .CW     (CNT_W),
      .FOLLOW ((g == 0) ? 1'b0 : 1'b1)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .per_i     (per_act),
      .half_i    (half_cmp),
      .restart_i (restart_vec[g]),
      .cnt_o     (cnt[g]),
      .pwm_o     (pwm[g])
    );
  end

  assign ref_pwm_o   = pwm[0];
  assign ref_pwm_n_o = ~pwm[0];
  assign sec_pwm_o   = pwm[1];
  assign sec_pwm_n_o = ~pwm[1];
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          ref_pwm_o,
  input logic          ref_pwm_n_o,
  input logic          sec_pwm_o,
  input logic          sec_pwm_n_o,
  input logic [CW-1:0] m_cnt,
  input logic [CW-1:0] s_cnt,
  input logic [CW-1:0] per_act,
  input logic [CW-1:0] half_cmp,
  input logic [CW-1:0] sh_cmp,
  input logic          sec_restart,
  input logic          m_wrap,
  input logic          preload
);
  logic [1:0] rs_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rs_n <= '0;
    else if (!en_i || m_wrap)  rs_n <= '0;
    else if (sec_restart && rs_n != 2'd3) rs_n <= rs_n + 2'd1;
  end

  assert_idle_outputs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ref_pwm_o && !sec_pwm_o && ref_pwm_n_o && sec_pwm_n_o && m_cnt == '0 && s_cnt == '0));

  assert_ref_rise_at_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_pwm_o) |-> m_cnt == '0);

  assert_ref_fall_at_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ref_pwm_o) && $past(en_i) && $past(per_act) > CW'(7)) |-> m_cnt == $past(half_cmp) + CW'(1));

  assert_sec_rise_on_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_pwm_o) |-> (s_cnt == '0 && $past(m_cnt) == $past(sh_cmp)));

  assert_single_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_restart |-> rs_n == 2'd0);

  assert_preload_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && preload && !m_wrap) |=> ($stable(sh_cmp) && $stable(per_act)));

  assert_shift_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_act > CW'(3)) |-> (sh_cmp < per_act && sh_cmp != CW'(1) && sh_cmp != CW'(2)));

  assert_zero_duty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_cmp == '0) |=> (!$rose(ref_pwm_o) && !$rose(sec_pwm_o)));
endmodule

bind phase_pwm phase_pwm_chk #(.CW(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .ref_pwm_o   (ref_pwm_o),
  .ref_pwm_n_o (ref_pwm_n_o),
  .sec_pwm_o   (sec_pwm_o),
  .sec_pwm_n_o (sec_pwm_n_o),
  .m_cnt       (m_cnt),
  .s_cnt       (s_cnt),
  .per_act     (per_act),
  .half_cmp    (half_cmp),
  .sh_cmp      (sh_cmp),
  .sec_restart (sec_restart),
  .m_wrap      (m_wrap),
  .preload     (preload)
);

// File: tb/phase_pwm_bench.sv
module phase_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ref_o, ref_n, sec_o, sec_n;

  int n_chk = 0, n_fail = 0;

  phase_pwm u_phase_pwm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .ref_pwm_o   (ref_o),
    .ref_pwm_n_o (ref_n),
    .sec_pwm_o   (sec_o),
    .sec_pwm_n_o (sec_n)
  );

  always #2.5ns clk = ~clk;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] sh;
    logic [15:0] lag;
    logic [15:0] hi;
  } vec_t;

  // period, written phase, expected lag (clamped phase + 1), expected high time
  localparam vec_t VECS [8] = '{
    '{16'd99,  16'd0,   16'd1,   16'd50},
    '{16'd99,  16'd30,  16'd31,  16'd50},
    '{16'd99,  16'd1,   16'd4,   16'd50},
    '{16'd99,  16'd2,   16'd4,   16'd50},
    '{16'd99,  16'd99,  16'd99,  16'd50},
    '{16'd99,  16'd500, 16'd99,  16'd50},
    '{16'd199, 16'd150, 16'd151, 16'd100},
    '{16'd63,  16'd10,  16'd11,  16'd32}
  };

  // edge monitor, sampled on the falling clock edge
  int cyc = 0;
  int ref_rise_cyc = 0, ref_per = 0, ref_hi_len = 0, ref_rise_n = 0, ref_fall_n = 0;
  int sec_rise_cyc = 0, sec_edge_cyc = 0, sec_hi_len = 0, sec_rise_n = 0, sec_fall_n = 0;
  int min_len = 1000000;
  bit mon_on = 1'b0;
  logic ref_q = 1'b0, sec_q = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ref_o && !ref_q) begin
      ref_per      = cyc - ref_rise_cyc;
      ref_rise_cyc = cyc;
      ref_rise_n++;
    end
    if (!ref_o && ref_q) begin
      ref_hi_len = cyc - ref_rise_cyc;
      ref_fall_n++;
    end
    if (sec_o != sec_q) begin
      if (mon_on && (cyc - sec_edge_cyc) < min_len) min_len = cyc - sec_edge_cyc;
      sec_edge_cyc = cyc;
      if (sec_o) begin
        sec_rise_cyc = cyc;
        sec_rise_n++;
      end else begin
        sec_hi_len = cyc - sec_rise_cyc;
        sec_fall_n++;
      end
    end
    ref_q = ref_o;
    sec_q = sec_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
  endtask

  task automatic wait_ref_rise(input int k);
    repeat (k) begin
      int n;
      n = ref_rise_n;
      while (ref_rise_n == n) @(posedge clk);
    end
  endtask

  task automatic wait_ref_fall(input int k);
    repeat (k) begin
      int n;
      n = ref_fall_n;
      while (ref_fall_n == n) @(posedge clk);
    end
  endtask

  task automatic wait_sec_rise(input int k);
    repeat (k) begin
      int n;
      n = sec_rise_n;
      while (sec_rise_n == n) @(posedge clk);
    end
  endtask

  task automatic wait_sec_fall(input int k);
    repeat (k) begin
      int n;
      n = sec_fall_n;
      while (sec_fall_n == n) @(posedge clk);
    end
  endtask

  task automatic step(input logic [15:0] sh, input int d);
    wait_ref_rise(1);
    repeat (d) @(posedge clk);
    wr(2'd1, sh);
    wait_sec_rise(3);
  endtask

  // large phase steps in both directions at several offsets in the period
  task automatic big_steps(input logic pre, input string req);
    set_en(1'b0);
    wr(2'd2, {15'd0, pre});
    wr(2'd0, 16'd99);
    wr(2'd1, 16'd70);
    set_en(1'b1);
    wait_sec_rise(3);
    min_len = 1000000;
    mon_on  = 1'b1;
    step(16'd10, 30);   // -60%
    step(16'd70, 40);   // +60%
    step(16'd10, 5);    // -60%
    step(16'd80, 30);   // +70%
    step(16'd10, 50);   // -70%
    mon_on = 1'b0;
    chk({req, " min follower pulse >= 50"}, (min_len >= 50) ? 50 : min_len, 50);
    wait_sec_rise(1);
    chk({req, " lag after steps"}, sec_rise_cyc - ref_rise_cyc, 11);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {ref_o, sec_o, ref_n, sec_n}, 4'b0011);
    rst_n = 1'b1;
    set_en(1'b1);
    repeat (2000) @(posedge clk);
    @(negedge clk);
    chk("R1 default period keeps reference low", ref_o, 0);
    chk("R1 default phase 0 sets follower", sec_o, 1);

    // R2 R4 R8: steady-state table
    for (int i = 0; i < 8; i++) begin
      set_en(1'b0);
      wr(2'd0, VECS[i].per);
      wr(2'd1, VECS[i].sh);
      set_en(1'b1);
      wait_sec_rise(4);
      chk($sformatf("R4 R8 lag vec %0d", i), sec_rise_cyc - ref_rise_cyc, int'(VECS[i].lag));
      wait_sec_fall(1);
      chk($sformatf("R4 follower high time vec %0d", i), sec_hi_len, int'(VECS[i].hi));
      wait_ref_rise(2);
      chk($sformatf("R2 reference period vec %0d", i), ref_per, int'(VECS[i].per) + 1);
      wait_ref_fall(1);
      chk($sformatf("R2 reference high time vec %0d", i), ref_hi_len, int'(VECS[i].hi));
    end

    // R3: complements track outputs
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (ref_n !== ~ref_o || sec_n !== ~sec_o) bad++;
      end
      chk("R3 complement mismatches", bad, 0);
    end

    // R5: preload holds the new phase until the wrap
    set_en(1'b0);
    wr(2'd0, 16'd99);
    wr(2'd1, 16'd50);
    set_en(1'b1);
    wait_sec_rise(3);
    wait_ref_rise(1);
    wr(2'd1, 16'd20);
    wait_sec_rise(1);
    chk("R5 old phase kept this period", sec_rise_cyc - ref_rise_cyc, 51);
    wait_sec_rise(1);
    chk("R5 new phase after wrap", sec_rise_cyc - ref_rise_cyc, 21);

    // R6: preload off applies at once
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd50);
    wait_sec_rise(3);
    wait_ref_rise(1);
    wr(2'd1, 16'd20);
    wait_sec_rise(1);
    chk("R6 immediate phase", sec_rise_cyc - ref_rise_cyc, 21);

    // R7: big steps with and without preload
    big_steps(1'b1, "R7 preload on");
    big_steps(1'b0, "R6 R7 preload off");

    // R10: idle while disabled, writes kept
    set_en(1'b0);
    repeat (2) @(negedge clk);
    chk("R10 idle outputs", {ref_o, sec_o, ref_n, sec_n}, 4'b0011);
    wr(2'd1, 16'd40);
    set_en(1'b1);
    wait_sec_rise(2);
    chk("R10 write while disabled used", sec_rise_cyc - ref_rise_cyc, 41);

    // R9: zero duty and raised half compare
    set_en(1'b0);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd0);
    set_en(1'b1);
    begin
      int highs;
      highs = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (ref_o || sec_o) highs++;
      end
      chk("R9 zero duty high samples", highs, 0);
    end
    set_en(1'b0);
    wr(2'd0, 16'd5);
    set_en(1'b1);
    wait_ref_rise(2);
    chk("R9 short period", ref_per, 6);
    wait_ref_fall(1);
    chk("R9 raised half compare high time", ref_hi_len, 4);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule